// File: doc/BRIEF.md
# Timestamp Event Capture Unit

This block sits next to a free-running 64-bit time counter, which it does not own. Two asynchronous trigger inputs, a slave line and a master line, are synchronised and edge-detected. A rising edge on either line copies the current counter value into that line's 64-bit snapshot register. The same block also watches the counter against a programmable 64-bit target and accepts a one-cycle pulse-per-second strobe from the counter's neighbour.

Every cause posts a sticky pending flag in a shared event register. Each flag sits at a fixed bit position, and a mask bit at the same position in a control register enables it. The interrupt output is high while any enabled flag is pending. Software clears flags by writing ones.

The register port is a simple synchronous word interface. Writes take effect at the next clock edge. Reads are combinational on the address. A read strobe on a snapshot's upper-word address freezes that snapshot's lower word, so a 64-bit value read upper word first cannot tear. The target is written lower word first. The lower word is only staged until the upper word commits both halves together.

Top module: `tec_capture_top`

## Requirements
- R1: After reset the control register, the event register, both snapshots and `irq` are all zero, and the committed target reads all ones in both words.
- R2: A rising edge on `aux_trig[0]` (slave) is seen through a two-flop synchroniser. At the third rising clock edge after the input rises, the value of `time_now` is stored in the slave snapshot and event bit 2 is set. An input held high captures only once.
- R3: A rising edge on `aux_trig[1]` (master) behaves the same way, filling the master snapshot and setting event bit 3.
- R4: A one-cycle `pps_pulse` sets event bit 4 at the next clock edge.
- R5: Writing the event register at address 1 clears each of bits 1 to 4 that is written as 1 and leaves bits written as 0 alone. Bit 0 and bits 5 and up always read 0.
- R6: If a cause sets its flag in the same cycle as a write-one clear of that flag, the flag stays set.
- R7: A new trigger while the earlier flag is still pending overwrites the snapshot with the newer time.
- R8: Address 2 takes the target's lower word and address 3 its upper word. Writing address 2 alone leaves the committed target unchanged. Writing address 3 commits {upper, staged lower} and arms the compare. Reads of addresses 2 and 3 return the committed target.
- R9: While armed, the first clock edge at which the full 64-bit `time_now` is greater than or equal to the target sets event bit 1 and disarms the compare. The flag stays set until software clears it, and it is not set again until the next commit.
- R10: The control register at address 0 holds the mask bits at positions 1 (target), 2 (slave), 3 (master) and 4 (PPS). Other bits read 0. `irq` is the OR over causes of flag AND mask.
- R11: Snapshot words sit at address 4 (slave upper), 5 (slave lower), 6 (master upper) and 7 (master lower). A read with `rd_en` at an upper address latches that snapshot's lower word. Its lower address returns the latched word, even if a newer capture has since landed.
- R12: A falling edge on a trigger input sets no flag and leaves the snapshot unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| time_now | input | 64 | Current value of the running time counter |
| aux_trig | input | 2 | Asynchronous triggers: bit 0 slave, bit 1 master |
| pps_pulse | input | 1 | One-cycle pulse-per-second strobe, clock-synchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Read strobe; at an upper snapshot address it latches the lower word |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Combinational read data for `rd_addr` |
| irq | output | 1 | Interrupt: any pending cause whose mask bit is set |

## Verification
A trigger's capture and flag land on the third rising edge after the input rises. The PPS flag, the target flag, register writes and the lower-word latch land on the first edge after their stimulus. Read data and `irq` follow the registers with no further delay. The bench drives every input at the falling edge and changes `time_now` once per cycle along a trigger's path, so the captured value is the one present at that third edge. It samples results only after the counted edges, on a falling edge or a nanosecond after a read address is set.

// File: rtl/tec_pkg.sv
package tec_pkg;

    parameter int unsigned WORD_W  = 32;
    parameter int unsigned TIME_W  = 2 * WORD_W;
    parameter int unsigned ADDR_W  = 3;
    parameter int unsigned EVT_W   = 5;
    parameter int unsigned NUM_AUX = 2;

    // Fixed cause positions shared by the event and control registers
    localparam int unsigned BIT_TGT  = 1;
    localparam int unsigned BIT_AUX0 = 2;
    localparam int unsigned BIT_PPS  = 4;

    localparam logic [EVT_W-1:0] CAUSE_MASK = 5'b11110;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CTRL   = 3'd0,
        SEL_EVENT  = 3'd1,
        SEL_TGT_LO = 3'd2,
        SEL_TGT_HI = 3'd3,
        SEL_SLV_HI = 3'd4,
        SEL_SLV_LO = 3'd5,
        SEL_MST_HI = 3'd6,
        SEL_MST_LO = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic [EVT_W-1:0] set;
        logic [EVT_W-1:0] clr;
    } evt_upd_t;

    function automatic logic [EVT_W-1:0] cause_field(input logic [WORD_W-1:0] w);
        return w[EVT_W-1:0] & CAUSE_MASK;
    endfunction

    function automatic logic [WORD_W-1:0] pad_word(input logic [EVT_W-1:0] v);
        return {{(WORD_W-EVT_W){1'b0}}, v};
    endfunction

    // Upper snapshot word of channel ch sits at 4 + 2*ch, lower word one above
    function automatic logic [ADDR_W-1:0] snap_sel(input int unsigned ch, input bit upper);
        return ADDR_W'(4 + 2 * ch + (upper ? 0 : 1));
    endfunction

endpackage

// File: rtl/tec_edge_sync.sv
module tec_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], din};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign rise = sync_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/tec_snapshot.sv
module tec_snapshot #(
    parameter int unsigned TIME_W = 64,
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [TIME_W-1:0] time_now,
    input  logic              rd_upper,
    output logic [TIME_W-1:0] snap,
    output logic [WORD_W-1:0] lo_hold
);
    always_ff @(posedge clk) begin
        if (rst) begin
            snap    <= '0;
            lo_hold <= '0;
        end else begin
            if (capture) begin
                snap <= time_now;
            end
            if (rd_upper) begin
                lo_hold <= snap[WORD_W-1:0];
            end
        end
    end

endmodule

// File: rtl/tec_target_cmp.sv
module tec_target_cmp #(
    parameter int unsigned TIME_W = 64,
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [WORD_W-1:0] wdata,
    input  logic [TIME_W-1:0] time_now,
    output logic [TIME_W-1:0] target,
    output logic              hit
);
    logic [WORD_W-1:0] stage_q;
    logic              armed_q;

    assign hit = armed_q && (time_now >= target);

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            target  <= '1;
            armed_q <= 1'b0;
        end else begin
            if (wr_lo) begin
                stage_q <= wdata;
            end
            if (wr_hi) begin
                target  <= {wdata, stage_q};
                armed_q <= 1'b1;
            end else if (hit) begin
                armed_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/tec_event_reg.sv
module tec_event_reg
    import tec_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  evt_upd_t         upd,
    output logic [EVT_W-1:0] pending
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= '0;
        end else begin
            pending <= ((pending & ~upd.clr) | upd.set) & CAUSE_MASK;
        end
    end

endmodule

// File: rtl/tec_capture_top.sv
module tec_capture_top
    import tec_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [TIME_W-1:0]  time_now,
    input  logic [NUM_AUX-1:0] aux_trig,
    input  logic               pps_pulse,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [WORD_W-1:0]  wr_data,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [WORD_W-1:0]  rd_data,
    output logic               irq
);
    logic [NUM_AUX-1:0]             aux_rise;
    logic [NUM_AUX-1:0]             rd_upper_sel;
    logic [NUM_AUX-1:0][TIME_W-1:0] aux_snap;
    logic [NUM_AUX-1:0][WORD_W-1:0] aux_lo_hold;
    logic [EVT_W-1:0]               mask_q;
    logic [EVT_W-1:0]               evt_q;
    logic [TIME_W-1:0]              target;
    logic                           tgt_hit;
    evt_upd_t                       upd;
    reg_sel_e                       wsel;
    reg_sel_e                       rsel;

    assign wsel = reg_sel_e'(wr_addr);
    assign rsel = reg_sel_e'(rd_addr);

    for (genvar g = 0; g < NUM_AUX; g++) begin : g_aux
        tec_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst  (rst),
            .din  (aux_trig[g]),
            .rise (aux_rise[g])
        );

        assign rd_upper_sel[g] = rd_en && (rd_addr == snap_sel(g, 1'b1));

        tec_snapshot #(.TIME_W(TIME_W), .WORD_W(WORD_W)) u_snap (
            .clk      (clk),
            .rst      (rst),
            .capture  (aux_rise[g]),
            .time_now (time_now),
            .rd_upper (rd_upper_sel[g]),
            .snap     (aux_snap[g]),
            .lo_hold  (aux_lo_hold[g])
        );
    end

    tec_target_cmp #(.TIME_W(TIME_W), .WORD_W(WORD_W)) u_tgt (
        .clk      (clk),
        .rst      (rst),
        .wr_lo    (wr_en && wsel == SEL_TGT_LO),
        .wr_hi    (wr_en && wsel == SEL_TGT_HI),
        .wdata    (wr_data),
        .time_now (time_now),
        .target   (target),
        .hit      (tgt_hit)
    );

    always_comb begin
        upd.set = '0;
        upd.set[BIT_TGT] = tgt_hit;
        for (int i = 0; i < NUM_AUX; i++) begin
            upd.set[BIT_AUX0 + i] = aux_rise[i];
        end
        upd.set[BIT_PPS] = pps_pulse;
        upd.clr = (wr_en && wsel == SEL_EVENT) ? cause_field(wr_data) : '0;
    end

    tec_event_reg u_evt (
        .clk     (clk),
        .rst     (rst),
        .upd     (upd),
        .pending (evt_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (wr_en && wsel == SEL_CTRL) begin
            mask_q <= cause_field(wr_data);
        end
    end

    assign irq = |(evt_q & mask_q);

    always_comb begin
        case (rsel)
            SEL_CTRL:   rd_data = pad_word(mask_q);
            SEL_EVENT:  rd_data = pad_word(evt_q);
            SEL_TGT_LO: rd_data = target[WORD_W-1:0];
            SEL_TGT_HI: rd_data = target[TIME_W-1:WORD_W];
            SEL_SLV_HI: rd_data = aux_snap[0][TIME_W-1:WORD_W];
            SEL_SLV_LO: rd_data = aux_lo_hold[0];
            SEL_MST_HI: rd_data = aux_snap[1][TIME_W-1:WORD_W];
            SEL_MST_LO: rd_data = aux_lo_hold[1];
            default:    rd_data = '0;
        endcase
    end

endmodule

// File: rtl/tec_capture_checker.sv
module tec_capture_checker
    import tec_pkg::*;
(
    input logic                           clk,
    input logic                           rst,
    input logic [TIME_W-1:0]              time_now,
    input logic [NUM_AUX-1:0]             aux_rise,
    input logic                           pps_pulse,
    input logic                           wr_en,
    input logic [ADDR_W-1:0]              wr_addr,
    input logic [WORD_W-1:0]              wr_data,
    input logic [EVT_W-1:0]               evt_q,
    input logic [EVT_W-1:0]               mask_q,
    input logic [NUM_AUX-1:0][TIME_W-1:0] aux_snap,
    input logic                           irq
);
    logic evt_wr;
    assign evt_wr = wr_en && (wr_addr == ADDR_W'(SEL_EVENT));

    AST_RESET_CLEAN: assert property (@(posedge clk) $past(rst) |-> (evt_q == '0 && mask_q == '0)) else $error("reset state"); // R1
    AST_SLAVE_FLAG: assert property (@(posedge clk) disable iff (rst) aux_rise[0] |=> evt_q[BIT_AUX0]) else $error("slave flag"); // R2
    AST_SLAVE_SNAP: assert property (@(posedge clk) disable iff (rst) aux_rise[0] |=> aux_snap[0] == $past(time_now)) else $error("slave snap"); // R2
    AST_MASTER_FLAG: assert property (@(posedge clk) disable iff (rst) aux_rise[1] |=> evt_q[BIT_AUX0+1]) else $error("master flag"); // R3
    AST_PPS_FLAG: assert property (@(posedge clk) disable iff (rst) pps_pulse |=> evt_q[BIT_PPS]) else $error("pps flag"); // R4
    AST_CLEAR_ONE: assert property (@(posedge clk) disable iff (rst) (evt_wr && wr_data[BIT_AUX0] && !aux_rise[0]) |=> !evt_q[BIT_AUX0]) else $error("w1c"); // R5
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst) (evt_wr && wr_data[BIT_AUX0] && aux_rise[0]) |=> evt_q[BIT_AUX0]) else $error("set wins"); // R6
    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (rst) !aux_rise[0] |=> $stable(aux_snap[0])) else $error("snap hold"); // R12
    AST_TGT_STICKY: assert property (@(posedge clk) disable iff (rst) (evt_q[BIT_TGT] && !(evt_wr && wr_data[BIT_TGT])) |=> evt_q[BIT_TGT]) else $error("tgt sticky"); // R9
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst) ((evt_q & mask_q) == '0) |-> !irq) else $error("irq quiet"); // R10
    AST_IRQ_LOUD: assert property (@(posedge clk) disable iff (rst) ((evt_q & mask_q) != '0) |-> irq) else $error("irq loud"); // R10

endmodule

bind tec_capture_top tec_capture_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .time_now  (time_now),
    .aux_rise  (aux_rise),
    .pps_pulse (pps_pulse),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .evt_q     (evt_q),
    .mask_q    (mask_q),
    .aux_snap  (aux_snap),
    .irq       (irq)
);

// File: tb/tec_capture_top_test.sv
module tec_capture_top_test;

    logic        clk = 1'b0;
    logic        rst;
    logic [63:0] time_now;
    logic [1:0]  aux_trig;
    logic        pps_pulse;
    logic        wr_en;
    logic [2:0]  wr_addr;
    logic [31:0] wr_data;
    logic        rd_en;
    logic [2:0]  rd_addr;
    logic [31:0] rd_data;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    tec_capture_top uut (
        .clk       (clk),
        .rst       (rst),
        .time_now  (time_now),
        .aux_trig  (aux_trig),
        .pps_pulse (pps_pulse),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .irq       (irq)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] cause_bit(input int unsigned ch);
        return 5'b00100 << ch;   // 0 slave -> bit 2, 1 master -> bit 3, 2 pps -> bit 4
    endfunction

    // All tasks start and end just after a falling edge
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input bit upper, output logic [31:0] d);
        rd_addr = a; rd_en = upper;
        #1;
        d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fire(input int unsigned ch, input logic [63:0] base,
                        input logic [31:0] clr, output logic [63:0] exp);
        if (ch == 2) begin
            pps_pulse = 1'b1;
            if (clr != 0) begin wr_en = 1'b1; wr_addr = 3'd1; wr_data = clr; end
            @(negedge clk);
            pps_pulse = 1'b0; wr_en = 1'b0;
            exp = '0;
        end else begin
            aux_trig[ch] = 1'b1; time_now = base;
            @(negedge clk);
            time_now = base + 1;
            @(negedge clk);
            time_now = base + 2;
            if (clr != 0) begin wr_en = 1'b1; wr_addr = 3'd1; wr_data = clr; end
            @(negedge clk);
            wr_en = 1'b0;
            time_now = base + 3;
            exp = base + 2;
        end
    endtask

    task automatic release_trig(input int unsigned ch);
        if (ch < 2) aux_trig[ch] = 1'b0;
        idle(3);
    endtask

    task automatic read_snap(input int unsigned ch, output logic [63:0] v);
        logic [31:0] h, l;
        rd(3'(4 + 2 * ch), 1'b1, h);
        rd(3'(5 + 2 * ch), 1'b0, l);
        v = {h, l};
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [63:0] v, exp, exp_old;
        logic [4:0]  evt_m, mask_m, c;
        int unsigned ch, seed;

        seed = $urandom(32'h5EED_0042);
        rst = 1'b1; time_now = '0; aux_trig = '0; pps_pulse = 1'b0;
        wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_en = 1'b0; rd_addr = '0;
        idle(3);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(3'd0, 1'b0, d); check("R1 ctrl", d, 0);
        rd(3'd1, 1'b0, d); check("R1 event", d, 0);
        check("R1 irq", irq, 0);
        read_snap(0, v); check("R1 slave snap", v, 0);
        read_snap(1, v); check("R1 master snap", v, 0);
        rd(3'd2, 1'b0, d); check("R1 target lo", d, 32'hFFFF_FFFF);
        rd(3'd3, 1'b0, d); check("R1 target hi", d, 32'hFFFF_FFFF);

        // R2 slave capture; level held high does not retrigger
        fire(0, 64'h1234_5678_9ABC_0000, 0, exp);
        rd(3'd1, 1'b0, d); check("R2 slave flag", d, 32'h4);
        read_snap(0, v); check("R2 slave snap", v, exp);
        wr(3'd1, 32'h4);
        idle(3);
        rd(3'd1, 1'b0, d); check("R2 held level no retrigger", d, 0);

        // R12 falling edge is not an event
        release_trig(0);
        idle(2);
        rd(3'd1, 1'b0, d); check("R12 falling edge flag", d, 0);
        read_snap(0, v); check("R12 falling edge snap", v, exp);

        // R3 master capture
        fire(1, 64'h0000_00AB_FFFF_FFFE, 0, exp);
        rd(3'd1, 1'b0, d); check("R3 master flag", d, 32'h8);
        read_snap(1, v); check("R3 master snap", v, exp);
        release_trig(1);

        // R10 masking and irq
        check("R10 irq masked", irq, 0);
        wr(3'd0, 32'h8);
        check("R10 irq master enabled", irq, 1);
        rd(3'd0, 1'b0, d); check("R10 ctrl readback", d, 32'h8);
        wr(3'd0, 32'h4);
        check("R10 irq other mask", irq, 0);
        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, 1'b0, d); check("R10 ctrl unused bits", d, 32'h1E);

        // R4 pps
        fire(2, 0, 0, exp);
        rd(3'd1, 1'b0, d); check("R4 pps flag", d, 32'h18);

        // R5 write-one clear
        wr(3'd1, 32'h0);
        rd(3'd1, 1'b0, d); check("R5 write zero keeps", d, 32'h18);
        wr(3'd1, 32'hFFFF_FFE1);
        rd(3'd1, 1'b0, d); check("R5 non-cause bits", d, 32'h18);
        wr(3'd1, 32'h10);
        rd(3'd1, 1'b0, d); check("R5 clear pps only", d, 32'h8);
        wr(3'd1, 32'hFFFF_FFFF);
        rd(3'd1, 1'b0, d); check("R5 clear all", d, 0);
        check("R5 irq after clear", irq, 0);

        // R7 overwrite while pending
        fire(0, 64'h0000_0001_0000_0100, 0, exp_old);
        release_trig(0);
        fire(0, 64'h0000_0002_0000_0200, 0, exp);
        rd(3'd1, 1'b0, d); check("R7 still pending", d, 32'h4);
        read_snap(0, v); check("R7 newer time", v, exp);
        release_trig(0);

        // R6 set beats clear in the same cycle
        fire(0, 64'h0000_0003_0000_0300, 32'h4, exp);
        rd(3'd1, 1'b0, d); check("R6 set wins", d, 32'h4);
        read_snap(0, v); check("R6 snap", v, exp);
        release_trig(0);

        // R11 upper read latches lower word
        rd(3'd4, 1'b1, d); check("R11 upper word", d, exp[63:32]);
        exp_old = exp;
        fire(0, 64'h0000_0004_0000_0400, 0, exp);
        rd(3'd5, 1'b0, d); check("R11 held lower word", d, exp_old[31:0]);
        read_snap(0, v); check("R11 fresh pair", v, exp);
        release_trig(0);
        wr(3'd1, 32'h1E);

        // R8 / R9 target compare
        time_now = 64'd5;
        wr(3'd2, 32'h10);
        rd(3'd2, 1'b0, d); check("R8 staged lower not committed", d, 32'hFFFF_FFFF);
        wr(3'd3, 32'h0);
        rd(3'd2, 1'b0, d); check("R8 committed lower", d, 32'h10);
        rd(3'd3, 1'b0, d); check("R8 committed upper", d, 0);
        rd(3'd1, 1'b0, d); check("R9 below target", d, 0);
        time_now = 64'h10;
        @(negedge clk);
        rd(3'd1, 1'b0, d); check("R9 equal hits", d, 32'h2);
        time_now = 64'h20;
        idle(2);
        rd(3'd1, 1'b0, d); check("R9 sticky", d, 32'h2);
        check("R10 irq target", irq, 1);
        wr(3'd1, 32'h2);
        idle(3);
        rd(3'd1, 1'b0, d); check("R9 no refire", d, 0);
        wr(3'd2, 32'h0);
        wr(3'd3, 32'h1);
        time_now = 64'h0000_0000_FFFF_FFFF;
        idle(2);
        rd(3'd1, 1'b0, d); check("R9 upper word compared", d, 0);
        time_now = 64'h0000_0001_0000_0000;
        @(negedge clk);
        rd(3'd1, 1'b0, d); check("R9 64-bit hit", d, 32'h2);
        wr(3'd1, 32'h1E);

        // Random mix
        evt_m = '0;
        for (int it = 0; it < 40; it++) begin
            ch = $urandom % 3;
            mask_m = 5'(($urandom % 16) << 1);
            wr(3'd0, 32'(mask_m));
            v = {$urandom, $urandom};
            fire(ch, v, 0, exp);
            evt_m = evt_m | cause_bit(ch);
            rd(3'd1, 1'b0, d); check($sformatf("R2 R3 R4 random flags %0d", it), d, 32'(evt_m));
            check($sformatf("R10 random irq %0d", it), irq, |(evt_m & mask_m));
            if (ch < 2) begin
                read_snap(ch, v); check($sformatf("R2 R3 random snap %0d", it), v, exp);
            end
            release_trig(ch);
            c = 5'(($urandom % 16) << 1);
            wr(3'd1, 32'(c));
            evt_m = evt_m & ~c;
            rd(3'd1, 1'b0, d); check($sformatf("R5 random clear %0d", it), d, 32'(evt_m));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule